// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every data beat of a memory burst. A single-cycle `start` pulse captures a starting column, a burst-length code and an ordering choice. From the next clock onward, the block presents one column address per cycle until the burst is complete.

Only the low field that the burst length selects moves from beat to beat. That field is one bit wide for two beats, two bits for four beats and three bits for eight beats. It never carries into the bits above it, so every burst stays inside its aligned block, and the upper column bits pass through unchanged.

Two orderings are offered. The wrapping-increment order adds the beat index to the low field. The bit-flip order XORs the beat index into the low field. Flags mark the first and the final beat of each burst. A new `start` during a burst abandons it at once and begins the new burst.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, and whenever no burst is active, `valid`, `first_beat` and `last_beat` are 0 and `col_out` is all zeros.
- R2: A `start` sampled at a clock edge makes the next cycle carry beat 0. In that cycle `valid`=1, `first_beat`=1, and `col_out` equals the captured `col_in`.
- R3: `bl_sel` selects the beat count. 2'b00 gives 2 beats, 2'b01 gives 4 beats, and 2'b10 or 2'b11 gives 8 beats. `valid` stays high for exactly that many consecutive cycles.
- R4: With `burst_type`=0, beat k has a low field equal to (start low field + k) modulo the beat count.
- R5: With `burst_type`=1, beat k has a low field equal to the start low field XOR k.
- R6: Column bits above the selected low field keep their captured values on every beat.
- R7: `last_beat` is 1 only on the final beat. In the cycle after the final beat, `valid` is 0 unless a new `start` was sampled.
- R8: A `start` sampled during a burst, including on its final beat, begins the new burst on the next cycle, with no idle cycle and no further beats of the old burst.
- R9: Changes on `col_in`, `bl_sel` and `burst_type` while no `start` is present do not affect the burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that captures the settings and begins a burst |
| col_in | input | COL_W | Starting column address |
| bl_sel | input | 2 | Burst-length code |
| burst_type | input | 1 | 0 = wrapping increment, 1 = bit-flip order |
| col_out | output | COL_W | Column address of the current beat |
| valid | output | 1 | High while a beat is presented |
| first_beat | output | 1 | High on beat 0 |
| last_beat | output | 1 | High on the final beat |

## Verification
Every combination of ordering and length code is run from each of the eight low-field offsets, with random upper bits. Because the increment order and the XOR order differ only when a carry would occur, the offsets are what separate the two orders, and they also expose any carry that leaks into the upper bits. The unused length code is run in the same way and must behave exactly like the eight-beat code. Random bursts are then cut short by a new `start` at a random beat or chained back to back on the final beat, which shows whether the restart takes effect at once. Throughout each burst the inputs are scrambled, which shows whether the captured settings truly hold.

// File: rtl/bcas_pkg.sv
package bcas_pkg;

    localparam int IDX_W = 3;

    typedef enum logic [1:0] {
        BL_TWO   = 2'b00,
        BL_FOUR  = 2'b01,
        BL_EIGHT = 2'b10,
        BL_SPARE = 2'b11
    } bl_code_e;

    typedef enum logic {
        ORD_WRAP = 1'b0,
        ORD_FLIP = 1'b1
    } order_e;

    function automatic logic [IDX_W-1:0] field_mask(bl_code_e code);
        case (code)
            BL_TWO:  return 3'b001;
            BL_FOUR: return 3'b011;
            default: return 3'b111;
        endcase
    endfunction

endpackage

// File: rtl/bcas_addr_gen.sv
module bcas_addr_gen
    import bcas_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base,
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W-1:0] mask,
    input  order_e           order,
    output logic [COL_W-1:0] addr
);

    logic [IDX_W-1:0] low_base;
    logic [IDX_W-1:0] wrap_low;
    logic [IDX_W-1:0] flip_low;
    logic [IDX_W-1:0] pick_low;

    always_comb begin
        low_base = base[IDX_W-1:0];
        wrap_low = low_base + idx;
        flip_low = low_base ^ idx;
        pick_low = (order == ORD_FLIP) ? flip_low : wrap_low;
    end

    assign addr[COL_W-1:IDX_W] = base[COL_W-1:IDX_W];

    for (genvar b = 0; b < IDX_W; b++) begin : g_bit
        assign addr[b] = mask[b] ? pick_low[b] : low_base[b];
    end

endmodule

// File: rtl/bcas_beat_track.sv
module bcas_beat_track
    import bcas_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] mask,
    output logic [IDX_W-1:0] idx,
    output logic             active,
    output logic             first,
    output logic             last
);

    typedef struct packed {
        logic             act;
        logic [IDX_W-1:0] idx;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (start) begin
            trk_d.act = 1'b1;
            trk_d.idx = '0;
        end else if (trk_q.act) begin
            if (trk_q.idx == mask) begin
                trk_d.act = 1'b0;
                trk_d.idx = '0;
            end else begin
                trk_d.idx = trk_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign idx    = trk_q.idx;
    assign active = trk_q.act;
    assign first  = trk_q.act && (trk_q.idx == '0);
    assign last   = trk_q.act && (trk_q.idx == mask);

    p_idx_in_field_r3: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> ((idx & ~mask) == '0));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !last && !start) |=> (active && idx == $past(idx) + 1'b1));

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcas_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] col_in,
    input  logic [1:0]       bl_sel,
    input  logic             burst_type,
    output logic [COL_W-1:0] col_out,
    output logic             valid,
    output logic             first_beat,
    output logic             last_beat
);

    typedef struct packed {
        logic [COL_W-1:0] base;
        logic [IDX_W-1:0] mask;
        order_e           order;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [IDX_W-1:0] beat_idx;
    logic             beat_act;
    logic [COL_W-1:0] gen_addr;

    always_comb begin
        cfg_d = cfg_q;
        if (start) begin
            cfg_d.base  = col_in;
            cfg_d.mask  = field_mask(bl_code_e'(bl_sel));
            cfg_d.order = order_e'(burst_type);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    bcas_beat_track u_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .mask   (cfg_q.mask),
        .idx    (beat_idx),
        .active (beat_act),
        .first  (first_beat),
        .last   (last_beat)
    );

    bcas_addr_gen #(.COL_W(COL_W)) u_gen (
        .base  (cfg_q.base),
        .idx   (beat_idx),
        .mask  (cfg_q.mask),
        .order (cfg_q.order),
        .addr  (gen_addr)
    );

    assign valid   = beat_act;
    assign col_out = beat_act ? gen_addr : '0;

    p_beat0_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (valid && first_beat && col_out == $past(col_in)));

    p_upper_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && $past(valid) && !$past(start))
            |-> (col_out[COL_W-1:IDX_W] == $past(col_out[COL_W-1:IDX_W])));

    p_drop_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (last_beat && !start) |=> !valid);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (col_out == '0 && !first_beat && !last_beat));

    p_flags_apart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(first_beat && last_beat));

endmodule

// File: tb/sim_burst_col_seq.sv
`timescale 1ns/1ps
module sim_burst_col_seq;

    localparam int COL_W = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [COL_W-1:0] col_in = '0;
    logic [1:0]       bl_sel = '0;
    logic             burst_type = 1'b0;
    logic [COL_W-1:0] col_out;
    logic             valid, first_beat, last_beat;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .col_in(col_in),
        .bl_sel(bl_sel), .burst_type(burst_type), .col_out(col_out),
        .valid(valid), .first_beat(first_beat), .last_beat(last_beat)
    );

    function automatic int beats_of(logic [1:0] sel);
        return (sel == 2'b00) ? 2 : (sel == 2'b01) ? 4 : 8;
    endfunction

    function automatic logic [COL_W-1:0] want_col(logic [COL_W-1:0] c, logic [1:0] sel,
                                                  logic typ, int k);
        logic [COL_W-1:0] m;
        logic [COL_W-1:0] lo;
        m  = COL_W'(beats_of(sel) - 1);
        lo = typ ? ((c ^ COL_W'(k)) & m) : ((c + COL_W'(k)) & m);
        return (c & ~m) | lo;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Called at a negedge; drives start there and checks n_check beats.
    task automatic burst(logic [COL_W-1:0] c, logic [1:0] sel, logic typ,
                         int n_check, bit check_end);
        int bl;
        bl = beats_of(sel);
        start = 1'b1; col_in = c; bl_sel = sel; burst_type = typ;
        for (int k = 0; k < n_check; k++) begin
            @(negedge clk);
            if (k == 0) begin
                start = 1'b0;
                // R9: scramble settings while the burst runs
                col_in = COL_W'($urandom); bl_sel = 2'($urandom); burst_type = 1'($urandom);
            end
            chk("R2 R3 valid", int'(valid), 1);
            chk("R4 R5 R6 col_out R9", int'(col_out), int'(want_col(c, sel, typ, k)));
            chk("R2 first_beat", int'(first_beat), int'(k == 0));
            chk("R7 last_beat R3", int'(last_beat), int'(k == bl - 1));
        end
        if (check_end) begin
            @(negedge clk);
            chk("R7 R3 valid after end", int'(valid), 0);
            chk("R1 idle col_out", int'(col_out), 0);
            chk("R1 idle flags", int'({first_beat, last_beat}), 0);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        if (!done) $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1 reset valid", int'(valid), 0);
        chk("R1 reset col_out", int'(col_out), 0);
        chk("R1 reset flags", int'({first_beat, last_beat}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed sweep: both orders, all codes (spare code too), all offsets
        for (int t = 0; t < 2; t++)
            for (int s = 0; s < 4; s++)
                for (int o = 0; o < 8; o++)
                    burst({6'($urandom), 3'(o)}, 2'(s), 1'(t), beats_of(2'(s)), 1'b1);

        // Corner: all-ones start must not carry into upper bits (R6)
        burst(9'h1FF, 2'b10, 1'b0, 8, 1'b1);
        burst(9'h0FB, 2'b01, 1'b0, 4, 1'b1);

        // Back-to-back on the final beat (R8)
        burst(9'h0A5, 2'b01, 1'b0, 4, 1'b0);
        burst(9'h13E, 2'b10, 1'b1, 8, 1'b1);

        // Random bursts, some aborted mid-way by a new start (R8)
        for (int i = 0; i < 300; i++) begin
            logic [1:0] sel;
            int cut;
            sel = 2'($urandom);
            cut = 1 + int'($urandom_range(0, beats_of(sel) - 1));
            burst(COL_W'($urandom), sel, 1'($urandom), cut, 1'b0);
            if ($urandom_range(0, 3) == 0) begin
                start = 1'b0;
                repeat (8) @(negedge clk);
                chk("R1 R7 idle after burst", int'(valid), 0);
            end
        end
        burst(9'h055, 2'b00, 1'b1, 2, 1'b1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule